// File: doc/BRIEF.md
# DRAM Clock-Enable Power Controller

This block is the clock-enable state machine of a double-data-rate SDRAM. On each rising clock edge it looks at three things. The first is the clock-enable level of the previous cycle and of the current cycle. The second is the command presented on the select, row-strobe, column-strobe and write-enable pins. The third is whether every bank is idle. From these it decides whether the device stays in normal operation or enters one of three states: self-refresh, power-down or clock suspend. It also leaves those states when the same inputs call for it.

The controller reports its power state as a small code. It drives a command gate that tells downstream command logic whether to act on its inputs, and it raises a one-cycle flag when an input combination is not allowed. After self-refresh ends, a ready output stays low for a programmable recovery window of `TRC_CYCLES` clocks. The controller then returns to normal operation. The asynchronous wake-up path of a real device is modelled here as ordinary synchronous sampling. All pins are plain control and status signals with no handshake.

Top module: `ddr_cke_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_state` is NORMAL (code 0), `cmd_gate` and `sr_ready` are 1 and `illegal` is 0.
- R2: In NORMAL with `banks_idle` high and enable falling (prev 1, now 0), a refresh pattern enters SELF-REFRESH (code 3) on the next edge. The refresh pattern is cs_n 0, ras_n 0, cas_n 0, we_n 1.
- R3: In NORMAL with `banks_idle` high and enable falling, a quiet command enters POWER-DOWN (code 2). A quiet command is a deselect (cs_n 1) or a NOP (cs_n 0, ras_n 1, cas_n 1, we_n 1).
- R4: In NORMAL with `banks_idle` high and enable falling, any other command raises `illegal` for one cycle and the state stays NORMAL.
- R5: In NORMAL, enable falling with `banks_idle` low enters SUSPEND (code 1). Enable low on both cycles also enters SUSPEND, whatever the command and bank state.
- R6: In SUSPEND, the state returns to NORMAL when current enable is high and otherwise stays SUSPEND. `illegal` stays 0.
- R7: In SELF-REFRESH, enable low on both cycles holds the state. Enable rising with a quiet command enters EXIT-WAIT (code 4). Enable rising with any other command raises `illegal` and holds SELF-REFRESH.
- R8: EXIT-WAIT lasts exactly `TRC_CYCLES` cycles whatever the inputs, and then the state becomes NORMAL. `sr_ready` is 0 in SELF-REFRESH and EXIT-WAIT and 1 in every other state.
- R9: In POWER-DOWN, enable low on both cycles holds the state. Enable rising returns to NORMAL whatever the command.
- R10: In SELF-REFRESH or POWER-DOWN, a previous-cycle enable of 1 raises `illegal` for one cycle and leaves the state unchanged.
- R11: `cmd_gate` is 1 only in NORMAL.
- R12: In NORMAL, enable high on both cycles or enable rising keeps NORMAL with `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock enable sampled in the previous cycle |
| cke_now | input | 1 | Clock enable in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when all banks are idle |
| pwr_state | output | 3 | 0 NORMAL, 1 SUSPEND, 2 POWER-DOWN, 3 SELF-REFRESH, 4 EXIT-WAIT |
| cmd_gate | output | 1 | High when command logic may act on its inputs |
| illegal | output | 1 | One-cycle pulse after a disallowed combination |
| sr_ready | output | 1 | Low during self-refresh and its recovery window |

## Verification
The hardest situations to reach are the entry and exit decisions taken inside self-refresh and power-down. Those states can be entered only through one exact combination of enable edge, idle banks and command. The bench therefore resets the block for every case and drives that entry combination first. It confirms the state reached, then sweeps every pair of enable levels, all sixteen pin patterns and both bank conditions. The recovery window is checked by counting cycles while the enable and command pins keep changing.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL  = 3'd0,
    PS_SUSPEND = 3'd1,
    PS_PWRDN   = 3'd2,
    PS_SELFREF = 3'd3,
    PS_EXITWT  = 3'd4
  } pwr_state_e;

endpackage

// File: rtl/cke_cmd_class.sv
module cke_cmd_class (
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic is_refresh,
  output logic is_quiet
);

  logic is_desel;
  logic is_nop;

  always_comb begin
    is_desel   = cs_n;
    is_nop     = !cs_n && ras_n && cas_n && we_n;
    is_refresh = !cs_n && !ras_n && !cas_n && we_n;
    is_quiet   = is_desel || is_nop;
  end

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
  parameter int TRC_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CW = (TRC_CYCLES < 2) ? 1 : $clog2(TRC_CYCLES);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TRC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_VAL;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
  import cke_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_prev,
  input  logic       cke_now,
  input  logic       banks_idle,
  input  logic       is_refresh,
  input  logic       is_quiet,
  input  logic       tmr_done,
  output pwr_state_e state,
  output logic       tmr_load,
  output logic       illegal_q
);

  pwr_state_e nxt;
  logic       bad;
  logic       fall;
  logic       rise;
  logic       both_low;

  always_comb begin
    fall     = cke_prev && !cke_now;
    rise     = !cke_prev && cke_now;
    both_low = !cke_prev && !cke_now;
    nxt      = state;
    bad      = 1'b0;
    tmr_load = 1'b0;
    unique case (state)
      PS_NORMAL: begin
        if (fall) begin
          if (!banks_idle) begin
            nxt = PS_SUSPEND;
          end else if (is_refresh) begin
            nxt = PS_SELFREF;
          end else if (is_quiet) begin
            nxt = PS_PWRDN;
          end else begin
            bad = 1'b1;
          end
        end else if (both_low) begin
          nxt = PS_SUSPEND;
        end
      end
      PS_SUSPEND: begin
        if (cke_now) nxt = PS_NORMAL;
      end
      PS_PWRDN: begin
        if (cke_prev) begin
          bad = 1'b1;
        end else if (rise) begin
          nxt = PS_NORMAL;
        end
      end
      PS_SELFREF: begin
        if (cke_prev) begin
          bad = 1'b1;
        end else if (rise) begin
          if (is_quiet) begin
            nxt      = PS_EXITWT;
            tmr_load = 1'b1;
          end else begin
            bad = 1'b1;
          end
        end
      end
      PS_EXITWT: begin
        if (tmr_done) nxt = PS_NORMAL;
      end
      default: nxt = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_NORMAL;
      illegal_q <= 1'b0;
    end else begin
      state     <= nxt;
      illegal_q <= bad;
    end
  end

endmodule

// File: rtl/ddr_cke_pwr_ctrl.sv
module ddr_cke_pwr_ctrl
  import cke_pwr_pkg::*;
#(
  parameter int TRC_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_prev,
  input  logic       cke_now,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] pwr_state,
  output logic       cmd_gate,
  output logic       illegal,
  output logic       sr_ready
);

  logic       is_refresh;
  logic       is_quiet;
  logic       tmr_load;
  logic       tmr_done;
  pwr_state_e state;

  cke_cmd_class u_class (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .is_refresh(is_refresh),
    .is_quiet  (is_quiet)
  );

  cke_exit_timer #(.TRC_CYCLES(TRC_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .run  (state == PS_EXITWT),
    .done (tmr_done)
  );

  cke_state_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_prev  (cke_prev),
    .cke_now   (cke_now),
    .banks_idle(banks_idle),
    .is_refresh(is_refresh),
    .is_quiet  (is_quiet),
    .tmr_done  (tmr_done),
    .state     (state),
    .tmr_load  (tmr_load),
    .illegal_q (illegal)
  );

  assign pwr_state = state;
  assign cmd_gate  = (state == PS_NORMAL);
  assign sr_ready  = (state != PS_SELFREF) && (state != PS_EXITWT);

endmodule

// File: rtl/cke_pwr_checker.sv
module cke_pwr_checker #(
  parameter int TRC_CYCLES = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_prev,
  input logic       cke_now,
  input logic       banks_idle,
  input logic [2:0] pwr_state,
  input logic       illegal,
  input logic       sr_ready
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= (pwr_state == 3'd4) ? run_len + 1 : '0;
  end

  a_r2_low_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd2 || pwr_state == 3'd3) && $past(pwr_state) == 3'd0) |-> $past(banks_idle));

  a_r7_selfref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 && !cke_prev && !cke_now) |=> pwr_state == 3'd3);

  a_r9_pwrdn_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 && !cke_prev && cke_now) |=> pwr_state == 3'd0);

  a_r10_prev_high_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd2 || pwr_state == 3'd3) && cke_prev) |=> (illegal && $stable(pwr_state)));

  a_r8_not_ready_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd4 |-> !sr_ready);

  a_r8_wait_length: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0 && $past(pwr_state) == 3'd4) |-> run_len == TRC_CYCLES);

  a_r6_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd1 |=> !illegal);

endmodule

bind ddr_cke_pwr_ctrl cke_pwr_checker #(.TRC_CYCLES(TRC_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke_prev  (cke_prev),
  .cke_now   (cke_now),
  .banks_idle(banks_idle),
  .pwr_state (pwr_state),
  .illegal   (illegal),
  .sr_ready  (sr_ready)
);

// File: tb/ddr_cke_pwr_ctrl_test.sv
module ddr_cke_pwr_ctrl_test;

  localparam int TRC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke_prev = 1'b1, cke_now = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic       banks_idle = 1'b1;
  logic [2:0] pwr_state;
  logic       cmd_gate, illegal, sr_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ddr_cke_pwr_ctrl #(.TRC_CYCLES(TRC)) uut (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_now(cke_now),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .banks_idle(banks_idle), .pwr_state(pwr_state), .cmd_gate(cmd_gate),
    .illegal(illegal), .sr_ready(sr_ready)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit p, bit n, bit idle, logic [3:0] cmd);
    @(negedge clk);
    cke_prev = p; cke_now = n; banks_idle = idle;
    {cs_n, ras_n, cas_n, we_n} = cmd;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cke_prev = 1'b1; cke_now = 1'b1; banks_idle = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit quiet(logic [3:0] c);
    return c[3] || (c == 4'b0111);
  endfunction

  // returns {illegal, next_state}
  function automatic logic [3:0] model(int st, bit p, bit n, bit idle, logic [3:0] c);
    int nx = st;
    bit il = 1'b0;
    case (st)
      0: if (p && !n) begin
           if (!idle) nx = 1;
           else if (c == 4'b0001) nx = 3;
           else if (quiet(c)) nx = 2;
           else il = 1'b1;
         end else if (!p && !n) nx = 1;
      1: if (n) nx = 0;
      2: if (p) il = 1'b1; else if (n) nx = 0;
      3: if (p) il = 1'b1;
         else if (n) begin
           if (quiet(c)) nx = 4; else il = 1'b1;
         end
      default: nx = st;
    endcase
    return {il, 3'(nx)};
  endfunction

  function automatic string tag(int st, bit p, bit n, bit idle, logic [3:0] c);
    case (st)
      0: if (p && !n) begin
           if (!idle) return "R5";
           if (c == 4'b0001) return "R2";
           if (quiet(c)) return "R3";
           return "R4";
         end else if (!p && !n) return "R5";
         else return "R12";
      1: return "R6";
      2: return p ? "R10" : "R9";
      default: return p ? "R10" : "R7";
    endcase
  endfunction

  task automatic enter(int st);
    do_reset();
    case (st)
      1: step(1'b1, 1'b0, 1'b0, 4'b0111);
      2: step(1'b1, 1'b0, 1'b1, 4'b1000);
      3: step(1'b1, 1'b0, 1'b1, 4'b0001);
      default: ;
    endcase
    check(st == 2 ? "R3" : st == 3 ? "R2" : st == 1 ? "R5" : "R1", pwr_state, st);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1", pwr_state, 0);
    check("R1", cmd_gate, 1);
    check("R1", illegal, 0);
    check("R1", sr_ready, 1);

    for (int st = 0; st < 4; st++) begin
      for (int k = 0; k < 128; k++) begin
        bit p    = k[6];
        bit n    = k[5];
        bit idle = k[4];
        logic [3:0] c = 4'(k);
        logic [3:0] e;
        string r;
        enter(st);
        e = model(st, p, n, idle, c);
        r = tag(st, p, n, idle, c);
        step(p, n, idle, c);
        check(r, pwr_state, int'(e[2:0]));
        check(r, illegal, int'(e[3]));
        check("R11", cmd_gate, int'(e[2:0] == 3'd0));
        check("R8", sr_ready, int'(e[2:0] != 3'd3 && e[2:0] != 3'd4));
      end
    end

    // Recovery window with toggling inputs
    for (int v = 0; v < 4; v++) begin
      enter(3);
      step(1'b0, 1'b0, 1'b0, 4'b0000);
      check("R7", pwr_state, 3);
      check("R8", sr_ready, 0);
      step(1'b0, 1'b1, 1'b1, v[0] ? 4'b1000 : 4'b0111);
      for (int i = 0; i < TRC; i++) begin
        check("R8", pwr_state, 4);
        check("R8", sr_ready, 0);
        check("R11", cmd_gate, 0);
        step(1'(i + v), 1'(i + v + 1), 1'(v), 4'(i * 5 + v));
      end
      check("R8", pwr_state, 0);
      check("R8", sr_ready, 1);
      check("R11", cmd_gate, 1);
    end

    // illegal is a single-cycle pulse
    enter(0);
    step(1'b1, 1'b0, 1'b1, 4'b0100);
    check("R4", illegal, 1);
    step(1'b1, 1'b1, 1'b1, 4'b0111);
    check("R4", illegal, 0);
    check("R4", pwr_state, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule